// File: doc/BRIEF.md
# Compact Genetic Search Engine

This block runs a compact genetic search over a chromosome of `CHROM_LEN` bits. It does not store a population. Each bit position has an unsigned likelihood register of `PROB_W` bits. In every iteration the block draws two candidate chromosomes from those registers, using random words supplied from outside. It scores each candidate by how many ones it holds and nudges every register toward the better candidate at the positions where the two candidates disagree. When every register has reached one of its two bounds, the search is over: the block raises `ready` and presents the converged chromosome.

A sequencer advances the work one step per clock. The steps are draw, score, adjust and test, so one iteration always takes four clocks. A `start` pulse, accepted only while the block is idle or finished, puts every register back at its midpoint and clears the iteration counter. The random source, for example one LFSR per word, belongs to the surrounding logic. The word for candidate one at bit `i` sits in `rand_a[i*PROB_W +: PROB_W]`, and the word for candidate two sits in the same slice of `rand_b`.

Top module: `cga_engine`

## Requirements
- R1: After reset, `ready` is 0, `solution` is all zeros and `iter_count` is 0, and the block waits idle with no iteration running.
- R2: A `start` seen while idle or finished sets every likelihood register to the midpoint 2^(PROB_W-1), clears `iter_count` and `solution`, drops `ready` on the next clock and begins a new search.
- R3: In the draw step, bit i of a candidate is 1 exactly when that candidate's random word for bit i, sampled at that clock edge, is strictly less than register i. The random inputs are not used at any other time.
- R4: Candidate one wins when its count of ones is greater than or equal to candidate two's count, so a tie goes to candidate one. Otherwise candidate two wins.
- R5: At a bit where both candidates carry the same value, the register keeps its value.
- R6: At a bit where the candidates differ, the register rises by one step if the winner's bit is 1 and falls by one step if the winner's bit is 0.
- R7: A rise that would pass the maximum 2^PROB_W-1 lands on the maximum, and a fall that would go below 0 lands on 0.
- R8: The step equals (2^PROB_W-1) divided by POP_SIZE, rounded down. With the defaults (16 bits, 50) it is 1310, so 26 iterations drive a register from the midpoint to either bound.
- R9: Each of the steps draw, score, adjust and test takes exactly one clock. `iter_count` rises by one in the clock after each adjust step and wraps at its width.
- R10: After a test step that finds every register at 0 or at the maximum, `ready` becomes 1 and stays 1 until the next start. `solution` bit i then reads 1 when register i is at the maximum and 0 when it is at 0.
- R11: A `start` that arrives while a search is running has no effect on the search, on `iter_count` or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new search (accepted while idle or finished) |
| rand_a | input | CHROM_LEN*PROB_W | Random words for candidate one, one per bit |
| rand_b | input | CHROM_LEN*PROB_W | Random words for candidate two, one per bit |
| ready | output | 1 | Search has converged |
| solution | output | CHROM_LEN | Converged chromosome, valid while ready |
| iter_count | output | ITER_W | Completed iterations since the last start |

## Verification
The clock edge that accepts `start` moves the block into the draw step. That edge is counted as edge 0. The random words are then sampled at edges 1, 5, 9 and so on. `iter_count` reaches n at edge 4n-1, and `ready` appears at edge 4n for a search that converges in iteration n. The bench drives inputs just after a falling edge. It steps a behavioural model once for each rising edge, using the inputs that were applied at that edge, and compares `ready`, `solution` and `iter_count` at the next falling edge, so every result is checked in the clock it becomes due. Directed patterns pin down when a random word is read. They produce exact iteration totals that are worked out from the step size, with expected values of 26 and 31.

// File: rtl/cga_pkg.sv
package cga_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DRAW  = 3'd1,
    ST_SCORE = 3'd2,
    ST_ADJ   = 3'd3,
    ST_TEST  = 3'd4,
    ST_DONE  = 3'd5
  } cga_state_e;

endpackage

// File: rtl/cga_sampler.sv
module cga_sampler #(
  parameter int CHROM_LEN = 8,
  parameter int PROB_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          draw_en,
  input  logic [CHROM_LEN*PROB_W-1:0]   probs,
  input  logic [CHROM_LEN*PROB_W-1:0]   rand_a,
  input  logic [CHROM_LEN*PROB_W-1:0]   rand_b,
  output logic [CHROM_LEN-1:0]          cand_a,
  output logic [CHROM_LEN-1:0]          cand_b
);

  logic [CHROM_LEN-1:0] draw_a;
  logic [CHROM_LEN-1:0] draw_b;

  for (genvar g = 0; g < CHROM_LEN; g++) begin : g_bit
    always_comb begin
      draw_a[g] = rand_a[g*PROB_W +: PROB_W] < probs[g*PROB_W +: PROB_W];
      draw_b[g] = rand_b[g*PROB_W +: PROB_W] < probs[g*PROB_W +: PROB_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_a <= '0;
      cand_b <= '0;
    end else if (draw_en) begin
      cand_a <= draw_a;
      cand_b <= draw_b;
    end
  end

  AST_CAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !draw_en |=> ($stable(cand_a) && $stable(cand_b))); // R3

endmodule

// File: rtl/cga_judge.sv
module cga_judge #(
  parameter int CHROM_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 score_en,
  input  logic [CHROM_LEN-1:0] cand_a,
  input  logic [CHROM_LEN-1:0] cand_b,
  output logic                 a_wins
);

  localparam int CNT_W = $clog2(CHROM_LEN + 1);

  logic [CNT_W-1:0] ones_a;
  logic [CNT_W-1:0] ones_b;
  logic             a_wins_nxt;

  always_comb begin
    ones_a = '0;
    ones_b = '0;
    for (int i = 0; i < CHROM_LEN; i++) begin
      ones_a = ones_a + CNT_W'(cand_a[i]);
      ones_b = ones_b + CNT_W'(cand_b[i]);
    end
    a_wins_nxt = (ones_a >= ones_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_wins <= 1'b1;
    end else if (score_en) begin
      a_wins <= a_wins_nxt;
    end
  end

  AST_TIE_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (score_en && (cand_a == cand_b)) |=> a_wins); // R4

endmodule

// File: rtl/cga_prob_cell.sv
module cga_prob_cell #(
  parameter int PROB_W   = 16,
  parameter int POP_SIZE = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              adj_en,
  input  logic              a_wins,
  input  logic              bit_a,
  input  logic              bit_b,
  output logic [PROB_W-1:0] prob,
  output logic              at_max,
  output logic              at_min
);

  localparam logic [PROB_W-1:0] PMAX = '1;
  localparam logic [PROB_W-1:0] PMID = {1'b1, {(PROB_W-1){1'b0}}};
  localparam logic [PROB_W-1:0] STEP = PMAX / PROB_W'(POP_SIZE);

  logic [PROB_W:0]   sum_up;
  logic [PROB_W-1:0] prob_up;
  logic [PROB_W-1:0] prob_dn;
  logic              win_bit;
  logic              differ;
  logic [PROB_W-1:0] prob_nxt;

  always_comb begin
    sum_up  = {1'b0, prob} + {1'b0, STEP};
    prob_up = sum_up[PROB_W] ? PMAX : sum_up[PROB_W-1:0];
    prob_dn = (prob < STEP) ? '0 : (prob - STEP);
    win_bit = a_wins ? bit_a : bit_b;
    differ  = bit_a ^ bit_b;
    if (!differ) begin
      prob_nxt = prob;
    end else if (win_bit) begin
      prob_nxt = prob_up;
    end else begin
      prob_nxt = prob_dn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prob <= PMID;
    end else if (init) begin
      prob <= PMID;
    end else if (adj_en) begin
      prob <= prob_nxt;
    end
  end

  assign at_max = (prob == PMAX);
  assign at_min = (prob == '0);

  AST_INIT_MID: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (prob == PMID)); // R2

  AST_SAME_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_en && !init && (bit_a == bit_b)) |=> $stable(prob)); // R5

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_en && !init) |=>
      (({1'b0, prob} <= {1'b0, $past(prob)} + {1'b0, STEP}) &&
       ({1'b0, prob} + {1'b0, STEP} >= {1'b0, $past(prob)}))); // R6

  AST_MAX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_en && !init && at_max && (a_wins ? bit_a : bit_b)) |=> at_max); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adj_en && !init) |=> $stable(prob)); // R11

endmodule

// File: rtl/cga_fsm.sv
module cga_fsm
  import cga_pkg::*;
#(
  parameter int ITER_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              converged,
  output logic              init,
  output logic              draw_en,
  output logic              score_en,
  output logic              adj_en,
  output logic              test_en,
  output logic              done,
  output logic [ITER_W-1:0] iter_count
);

  cga_state_e state;
  cga_state_e state_nxt;

  always_comb begin
    init      = start && ((state == ST_IDLE) || (state == ST_DONE));
    state_nxt = state;
    unique case (state)
      ST_IDLE:  if (start) state_nxt = ST_DRAW;
      ST_DRAW:  state_nxt = ST_SCORE;
      ST_SCORE: state_nxt = ST_ADJ;
      ST_ADJ:   state_nxt = ST_TEST;
      ST_TEST:  state_nxt = converged ? ST_DONE : ST_DRAW;
      ST_DONE:  if (start) state_nxt = ST_DRAW;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= state_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iter_count <= '0;
    end else if (init) begin
      iter_count <= '0;
    end else if (adj_en) begin
      iter_count <= iter_count + 1'b1;
    end
  end

  assign draw_en  = (state == ST_DRAW);
  assign score_en = (state == ST_SCORE);
  assign adj_en   = (state == ST_ADJ);
  assign test_en  = (state == ST_TEST);
  assign done     = (state == ST_DONE);

  AST_DRAW_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAW) |=> (state == ST_SCORE)); // R9

  AST_ITER_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    adj_en |=> (iter_count == $past(iter_count) + 1'b1)); // R9

  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R10

  AST_RUN_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCORE) |=> (state == ST_ADJ)); // R11

endmodule

// File: rtl/cga_engine.sv
module cga_engine #(
  parameter int CHROM_LEN = 8,
  parameter int PROB_W    = 16,
  parameter int POP_SIZE  = 50,
  parameter int ITER_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [CHROM_LEN*PROB_W-1:0] rand_a,
  input  logic [CHROM_LEN*PROB_W-1:0] rand_b,
  output logic                        ready,
  output logic [CHROM_LEN-1:0]        solution,
  output logic [ITER_W-1:0]           iter_count
);

  logic                        init;
  logic                        draw_en;
  logic                        score_en;
  logic                        adj_en;
  logic                        test_en;
  logic                        done;
  logic                        a_wins;
  logic                        converged;
  logic [CHROM_LEN-1:0]        cand_a;
  logic [CHROM_LEN-1:0]        cand_b;
  logic [CHROM_LEN-1:0]        hit_max;
  logic [CHROM_LEN-1:0]        hit_min;
  logic [CHROM_LEN*PROB_W-1:0] probs;

  cga_fsm #(.ITER_W(ITER_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .converged  (converged),
    .init       (init),
    .draw_en    (draw_en),
    .score_en   (score_en),
    .adj_en     (adj_en),
    .test_en    (test_en),
    .done       (done),
    .iter_count (iter_count)
  );

  cga_sampler #(.CHROM_LEN(CHROM_LEN), .PROB_W(PROB_W)) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .draw_en (draw_en),
    .probs   (probs),
    .rand_a  (rand_a),
    .rand_b  (rand_b),
    .cand_a  (cand_a),
    .cand_b  (cand_b)
  );

  cga_judge #(.CHROM_LEN(CHROM_LEN)) u_judge (
    .clk      (clk),
    .rst_n    (rst_n),
    .score_en (score_en),
    .cand_a   (cand_a),
    .cand_b   (cand_b),
    .a_wins   (a_wins)
  );

  for (genvar g = 0; g < CHROM_LEN; g++) begin : g_cell
    cga_prob_cell #(.PROB_W(PROB_W), .POP_SIZE(POP_SIZE)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (init),
      .adj_en (adj_en),
      .a_wins (a_wins),
      .bit_a  (cand_a[g]),
      .bit_b  (cand_b[g]),
      .prob   (probs[g*PROB_W +: PROB_W]),
      .at_max (hit_max[g]),
      .at_min (hit_min[g])
    );
  end

  assign converged = &(hit_max | hit_min);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      solution <= '0;
    end else if (init) begin
      solution <= '0;
    end else if (test_en && converged) begin
      solution <= hit_max;
    end
  end

  assign ready = done;

  AST_READY_AT_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> converged); // R10

  AST_SOLUTION_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (solution == hit_max)); // R10

endmodule

// File: tb/tb_cga_engine.sv
module tb_cga_engine;

  localparam int  CL       = 8;
  localparam int  PW       = 16;
  localparam int  POP      = 50;
  localparam int  IW       = 16;
  localparam time CLK_PER  = 10ns;
  localparam longint PMAXV = (64'd1 << PW) - 1;
  localparam longint PMIDV = 64'd1 << (PW - 1);
  localparam longint STEPV = PMAXV / POP;

  logic                 clk;
  logic                 rst_n;
  logic                 start;
  logic [CL*PW-1:0]     rand_a;
  logic [CL*PW-1:0]     rand_b;
  logic                 ready;
  logic [CL-1:0]        solution;
  logic [IW-1:0]        iter_count;

  int checks;
  int failures;

  // behavioural reference
  int     m_phase;
  longint m_p [CL];
  bit     m_ca [CL];
  bit     m_cb [CL];
  bit     m_awin;
  int     m_iter;
  bit     m_ready;
  logic [CL-1:0] m_sol;

  cga_engine #(.CHROM_LEN(CL), .PROB_W(PW), .POP_SIZE(POP), .ITER_W(IW)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rand_a     (rand_a),
    .rand_b     (rand_b),
    .ready      (ready),
    .solution   (solution),
    .iter_count (iter_count)
  );

  initial clk = 1'b0;
  always #(CLK_PER / 2) clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_phase = 0;
    for (int i = 0; i < CL; i++) begin
      m_p[i] = PMIDV; m_ca[i] = 0; m_cb[i] = 0;
    end
    m_awin = 1; m_iter = 0; m_ready = 0; m_sol = '0;
  endtask

  task automatic model_init();
    for (int i = 0; i < CL; i++) m_p[i] = PMIDV;
    m_iter = 0; m_sol = '0; m_ready = 0; m_phase = 1;
  endtask

  // one rising edge of the reference, with the inputs applied at that edge
  task automatic model_edge();
    int na, nb;
    bit all_b, wb;
    case (m_phase)
      0: if (start) model_init();
      1: begin // R3
        for (int i = 0; i < CL; i++) begin
          m_ca[i] = longint'(rand_a[i*PW +: PW]) < m_p[i];
          m_cb[i] = longint'(rand_b[i*PW +: PW]) < m_p[i];
        end
        m_phase = 2;
      end
      2: begin // R4
        na = 0; nb = 0;
        for (int i = 0; i < CL; i++) begin na += m_ca[i]; nb += m_cb[i]; end
        m_awin = (na >= nb);
        m_phase = 3;
      end
      3: begin // R5 R6 R7 R8
        for (int i = 0; i < CL; i++) begin
          if (m_ca[i] != m_cb[i]) begin
            wb = m_awin ? m_ca[i] : m_cb[i];
            if (wb) m_p[i] = (m_p[i] + STEPV > PMAXV) ? PMAXV : m_p[i] + STEPV;
            else    m_p[i] = (m_p[i] < STEPV) ? 0 : m_p[i] - STEPV;
          end
        end
        m_iter = (m_iter + 1) % (1 << IW);
        m_phase = 4;
      end
      4: begin // R10
        all_b = 1;
        for (int i = 0; i < CL; i++)
          if (m_p[i] != 0 && m_p[i] != PMAXV) all_b = 0;
        if (all_b) begin
          for (int i = 0; i < CL; i++) m_sol[i] = (m_p[i] == PMAXV);
          m_phase = 5; m_ready = 1;
        end else begin
          m_phase = 1;
        end
      end
      default: if (start) model_init();
    endcase
  endtask

  // inputs already set after a falling edge; advance one clock and compare
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R10 ready", ready, m_ready);
    check("R10 solution", solution, m_sol);
    check("R9 iter_count", iter_count, m_iter);
  endtask

  task automatic set_pattern(input logic [CL-1:0] ones_a, input logic [CL-1:0] ones_b);
    for (int i = 0; i < CL; i++) begin
      rand_a[i*PW +: PW] = ones_a[i] ? '0 : '1;
      rand_b[i*PW +: PW] = ones_b[i] ? '0 : '1;
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic run_to_ready(input int cap);
    for (int n = 0; n < cap && !ready; n++) tick();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int exp_iter;
    int lim;
    checks = 0; failures = 0;
    rst_n = 1'b0; start = 1'b0;
    rand_a = '0; rand_b = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, idle without start
    check("R1 ready", ready, 0);
    check("R1 solution", solution, 0);
    check("R1 iter_count", iter_count, 0);
    repeat (6) tick();
    check("R1 idle iter_count", iter_count, 0);

    // R6 R7 R8: candidate one all ones, two all zeros
    exp_iter = int'((PMAXV - PMIDV + STEPV - 1) / STEPV);
    check("R8 step size", STEPV, 1310);
    set_pattern('1, '0);
    pulse_start();
    repeat (9) tick();
    // R11: start mid-run is ignored
    start = 1'b1; tick(); start = 1'b0;
    check("R11 iter after ignored start", iter_count, 2);
    run_to_ready(2000);
    check("R6 converged ready", ready, 1);
    check("R7 iterations to max", iter_count, exp_iter);
    check("R10 all-ones solution", solution, {CL{1'b1}});
    repeat (5) tick();
    check("R10 ready held", ready, 1);

    // R2: restart from done; R4 tie goes to candidate one
    set_pattern(8'h0F, 8'hF0);
    pulse_start();
    check("R2 ready dropped", ready, 0);
    check("R2 iter cleared", iter_count, 0);
    check("R2 solution cleared", solution, 0);
    run_to_ready(2000);
    check("R4 tie solution", solution, 8'h0F);
    check("R7 iterations to min", iter_count, exp_iter);

    // R5: identical zero candidates for five iterations leave registers alone
    set_pattern('0, '0);
    pulse_start();
    repeat (20) tick();
    check("R5 no convergence", ready, 0);
    set_pattern('1, '0);
    run_to_ready(2000);
    check("R5 iterations after hold", iter_count, exp_iter + 5);
    check("R5 solution", solution, {CL{1'b1}});

    // R3: random words, compared against the reference every clock
    for (int r = 0; r < 3; r++) begin
      pulse_start();
      lim = 0;
      while (!ready && lim < 30000) begin
        for (int i = 0; i < CL; i++) begin
          rand_a[i*PW +: PW] = PW'($urandom);
          rand_b[i*PW +: PW] = PW'($urandom);
        end
        tick();
        lim++;
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule